// File: doc/BRIEF.md
# Subroutine Call Bus Sequencer

This block runs the bus cycles of the absolute subroutine-call instruction in an 8-bit processor. A pulse on `start` hands it the processor's program counter, which must point at the call opcode, and its stack pointer. The block then takes six cycles on a single byte-wide memory port. It reads the opcode and then the low byte of the target. After one internal stack cycle it pushes the two return bytes into page one, and only then reads the high byte of the target. When it finishes, it returns the new program counter and the new stack pointer.

The read of the high byte comes after both pushes. A call whose operand bytes lie in the stack page therefore fetches whatever the pushes have just written there. The block keeps this exact order on purpose. The memory is expected to answer a read combinationally within the cycle, and a write is committed at the end of the cycle in which `mem_we` is high.

Top module: `jsr_bus_sequencer`

## Requirements
- R1: After reset `busy`, `done` and `mem_we` are 0, `pc_out` is 0x0000 and `sp_out` is 0xFF.
- R2: When the block is idle and `start` is high at a clock edge, it captures `pc_in` and `sp_in`. In the next cycle it reads the opcode at `pc_in`, with `busy` high.
- R3: In the second cycle the block reads the target low byte at opcode address + 1.
- R4: In the third cycle the block reads the stack location 0x0100 + SP without writing.
- R5: In the fourth cycle the block writes the high byte of the return address (opcode address + 2) to 0x0100 + SP. SP then drops by one.
- R6: In the fifth cycle the block writes the low byte of the return address to 0x0100 + the decremented SP. SP then drops by one again.
- R7: In the sixth cycle the block reads the target high byte at opcode address + 2. In the next cycle `done` is high for one cycle, `busy` is low, and `pc_out` equals low byte + (high byte << 8). Only the two push cycles drive `mem_we`.
- R8: SP wraps modulo 256. A push at SP = 0x00 goes to 0x0100, and the next push goes to 0x01FF.
- R9: When the target operand bytes lie at the addresses being pushed, the high byte fetched is the value the block has just pushed there. The low byte is the value that was in memory before the pushes.
- R10: Changes on `start` and `pc_in` while the block is busy have no effect on the bus sequence or on the result.
- R11: The return address and the operand addresses carry across a 256-byte page boundary as full 16-bit sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a call sequence (sampled while idle) |
| pc_in | input | 16 | Address of the call opcode |
| sp_in | input | 8 | Stack pointer at the start of the call |
| mem_rdata | input | 8 | Read data for the current `mem_addr` |
| mem_addr | output | 16 | Memory address of the current cycle |
| mem_we | output | 1 | Write strobe of the current cycle |
| mem_wdata | output | 8 | Write data, valid when `mem_we` is high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last bus cycle |
| pc_out | output | 16 | Program counter (the target after completion) |
| sp_out | output | 8 | Stack pointer (live, decremented by each push) |

## Verification
Each bus cycle is due a fixed number of clock edges after the edge that samples `start`. The opcode read is due one edge later and the target high-byte read six edges later. `done` follows one edge after that, together with the final `pc_out` and `sp_out`. The bench builds the full cycle-by-cycle expectation before a call begins, eight entries counting the idle cycle after `done`. At each falling edge it takes off the next entry and compares it with the ports, so every result is checked in exactly the cycle it is due. The expected high byte of the target is worked out from the push addresses: it is the pushed byte when the operand overlaps the stack writes, and the prior memory contents otherwise.

// File: rtl/jsr_bus_sequencer.sv
module jsr_bus_sequencer #(
  parameter int DW = 8,
  parameter int AW = 2 * DW,
  parameter logic [DW-1:0] STACK_PAGE = 1,
  parameter logic [DW-1:0] SP_RESET = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] sp_out
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_TLO, ST_GAP, ST_PUSHH, ST_PUSHL, ST_THI
  } st_t;

  st_t           st;
  logic [AW-1:0] pc_r;
  logic [DW-1:0] sp_r;
  logic [DW-1:0] tlo;
  logic          done_r;

  wire [AW-1:0] ret = pc_r + AW'(2);
  wire [AW-1:0] stk = {STACK_PAGE, sp_r};

  assign busy   = (st != ST_IDLE);
  assign done   = done_r;
  assign pc_out = pc_r;
  assign sp_out = sp_r;

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = '0;
    case (st)
      ST_OPC:   mem_addr = pc_r;
      ST_TLO:   mem_addr = pc_r + AW'(1);
      ST_GAP:   mem_addr = stk;
      ST_PUSHH: begin mem_addr = stk; mem_we = 1'b1; mem_wdata = ret[AW-1:DW]; end
      ST_PUSHL: begin mem_addr = stk; mem_we = 1'b1; mem_wdata = ret[DW-1:0]; end
      ST_THI:   mem_addr = pc_r + AW'(2);
      default:  mem_addr = pc_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pc_r   <= '0;
      sp_r   <= SP_RESET;
      tlo    <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= (st == ST_THI);
      case (st)
        ST_IDLE: if (start) begin
          pc_r <= pc_in;
          sp_r <= sp_in;
          st   <= ST_OPC;
        end
        ST_OPC:   st <= ST_TLO;
        ST_TLO:   begin tlo <= mem_rdata; st <= ST_GAP; end
        ST_GAP:   st <= ST_PUSHH;
        ST_PUSHH: begin sp_r <= sp_r - DW'(1); st <= ST_PUSHL; end
        ST_PUSHL: begin sp_r <= sp_r - DW'(1); st <= ST_THI; end
        ST_THI:   begin pc_r <= {mem_rdata, tlo}; st <= ST_IDLE; end
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R2: a start seen while idle opens the sequence with the opcode fetch
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !mem_we && mem_addr == $past(pc_in)));

  // R5 / R6 / R8: each push cycle lowers the stack pointer by one, modulo 256
  a_r5_push_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == DW'($past(sp_out) - DW'(1))));

  // R8: every write lands in the stack page
  a_r8_write_in_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[AW-1:DW] == STACK_PAGE));

  // R7: exactly two consecutive write cycles, then a read
  a_r7_two_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |=> (mem_we ##1 !mem_we));

  // R7: done is a single pulse outside busy
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !$past(done)));

  // R10: pc is held through the sequence until the final read
  a_r10_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !done) |-> $stable(pc_out) or mem_addr == pc_out + AW'(2));

endmodule

// File: tb/tb_jsr_bus_sequencer.sv
module tb_jsr_bus_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  sp_in = '0;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        busy;
  logic        done;
  logic [15:0] pc_out;
  logic [7:0]  sp_out;

  always #10 clk = ~clk;

  jsr_bus_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .sp_in(sp_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .pc_out(pc_out),
    .sp_out(sp_out)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [int];

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    mem_rdata = rd(mem_addr);
  end

  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic [7:0]  wd;
    logic        busy;
    logic        done;
    logic [15:0] pc;
    logic [7:0]  sp;
    string       tag;
  } rec_t;

  rec_t q[$];

  function automatic rec_t mk(input logic [15:0] a, input logic w, input logic [7:0] d,
                              input logic b, input logic dn, input logic [15:0] p,
                              input logic [7:0] s, input string t);
    rec_t r;
    r.addr = a; r.we = w; r.wd = d; r.busy = b; r.done = dn; r.pc = p; r.sp = s; r.tag = t;
    return r;
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      rec_t r;
      logic [7:0] awd;
      r = q.pop_front();
      awd = mem_we ? mem_wdata : 8'h00;
      checks++;
      if (mem_addr !== r.addr || mem_we !== r.we || awd !== r.wd || busy !== r.busy ||
          done !== r.done || pc_out !== r.pc || sp_out !== r.sp) begin
        errors++;
        $display("FAIL %s got addr=%h we=%b wd=%h busy=%b done=%b pc=%h sp=%h exp addr=%h we=%b wd=%h busy=%b done=%b pc=%h sp=%h",
                 r.tag, mem_addr, mem_we, awd, busy, done, pc_out, sp_out,
                 r.addr, r.we, r.wd, r.busy, r.done, r.pc, r.sp);
      end
    end
  end

  task automatic run_call(input logic [15:0] pc, input logic [7:0] sp, input bit hold,
                          input string tag);
    logic [15:0] ret, ah, al, tgt;
    logic [7:0] lo, hi, sp1, sp2;
    ret = pc + 16'd2;
    sp1 = sp - 8'd1;
    sp2 = sp - 8'd2;
    ah = {8'h01, sp};
    al = {8'h01, sp1};
    lo = rd(pc + 16'd1);
    if (pc + 16'd2 == al)      hi = ret[7:0];
    else if (pc + 16'd2 == ah) hi = ret[15:8];
    else                       hi = rd(pc + 16'd2);
    tgt = {hi, lo};
    @(negedge clk);
    pc_in = pc; sp_in = sp; start = 1'b1;
    @(posedge clk);
    #1;
    q.push_back(mk(pc,           0, 8'h00,     1, 0, pc,  sp,  {"R2 opcode ", tag}));
    q.push_back(mk(pc + 16'd1,   0, 8'h00,     1, 0, pc,  sp,  {"R3 low ", tag}));
    q.push_back(mk(ah,           0, 8'h00,     1, 0, pc,  sp,  {"R4 gap ", tag}));
    q.push_back(mk(ah,           1, ret[15:8], 1, 0, pc,  sp,  {"R5 push hi ", tag}));
    q.push_back(mk(al,           1, ret[7:0],  1, 0, pc,  sp1, {"R6 push lo ", tag}));
    q.push_back(mk(pc + 16'd2,   0, 8'h00,     1, 0, pc,  sp2, {"R7 high ", tag}));
    q.push_back(mk(tgt,          0, 8'h00,     0, 1, tgt, sp2, {"R7 done ", tag}));
    q.push_back(mk(tgt,          0, 8'h00,     0, 0, tgt, sp2, {"R7 idle ", tag}));
    if (hold) begin
      pc_in = 16'hBEEF; sp_in = 8'h11;
      repeat (6) @(negedge clk);
      start = 1'b0;
    end else begin
      start = 1'b0;
    end
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem[16'h1235] = 8'h78;
    mem[16'h1236] = 8'h56;
    mem[16'h20FF] = 8'h9A;
    mem[16'h2100] = 8'h4C;
    mem[16'h4001] = 8'h10;
    mem[16'h4002] = 8'h80;
    mem[16'h01F1] = 8'hAA;
    mem[16'h01F2] = 8'hBB;
    mem[16'h01E1] = 8'h33;
    mem[16'h01E2] = 8'h44;
    mem[16'h7001] = 8'hCD;
    mem[16'h7002] = 8'hAB;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || mem_we !== 1'b0 || pc_out !== 16'h0000 || sp_out !== 8'hFF) begin
      errors++;
      $display("FAIL R1 reset got busy=%b done=%b we=%b pc=%h sp=%h exp 0 0 0 0000 ff",
               busy, done, mem_we, pc_out, sp_out);
    end

    run_call(16'h1234, 8'hFD, 0, "R2 plain");
    run_call(16'h20FE, 8'h80, 0, "R11 page carry");
    run_call(16'h4000, 8'h00, 0, "R8 sp wrap");
    run_call(16'h01F0, 8'hF2, 0, "R9 hi overwritten by ret hi");
    run_call(16'h01E0, 8'hE3, 0, "R9 hi overwritten by ret lo");
    run_call(16'h7000, 8'h40, 1, "R10 start held");

    checks++;
    if (rd(16'h01E2) !== 8'hE2) begin
      errors++;
      $display("FAIL R9 stack byte got %h exp e2", rd(16'h01E2));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule